// File: doc/BRIEF.md
# Serial-In Shift Register with Strobed Output Latch

This block is a chain of serial-in register stages whose contents pass through a strobe-controlled holding latch. The latch feeds parallel outputs that can be tri-stated. Serial data is accepted on each rising edge of a slow shift clock. Two cascade outputs carry the last stage on to a following block: one changes on the rising edge of the shift clock and the other on the falling edge.

The block is fully synchronous to a fast system clock. The shift clock, the strobe and the serial data each pass through a two-flop synchroniser. Edges are found by comparing the newest synchronised sample with the one before it. The transparent latch is modelled as a register that reloads from the stages on every system cycle while the strobe is high. On the strobe's falling edge it makes a final capture and then holds. The tri-state outputs are available in two forms: a value bus with a per-bit drive-enable vector, and a wire with `z` on undriven bits.

Top module: `shift_latch_top`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 1 loads `ser_in` and every other stage loads the stage below it. `par_data[0]` reflects stage 1 and `par_data[7]` reflects stage 8.
- R2: After each rising edge of `shift_clk`, `casc_rise` equals the new stage 8, which is the value that stage 7 held before the edge.
- R3: On each falling edge of `shift_clk`, `casc_fall` takes the value of `casc_rise`, so it lags `casc_rise` by half a shift period.
- R4: While `strobe` is high, the latch reloads from the stages on every system cycle, one cycle behind them.
- R5: On the falling edge of `strobe`, the latch captures the stages. It then holds while `strobe` stays low, even if shifting continues.
- R6: When `out_en` is low, `par_drive` is all zeros and `par_q` is undriven. When `out_en` is high, all eight bits are driven with the latch contents.
- R7: `strobe` and `out_en` have no effect on the stages or on either cascade output. Without a shift-clock edge, the stages and both cascade outputs hold.
- R8: A synchronous active-high `rst` clears the stages, the latch, both cascade outputs and the synchronisers to 0.
- R9: A change on `shift_clk` or `strobe` takes effect at the third rising edge of `clk` after the change, counting two synchroniser flops and one state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into stage 1 |
| shift_clk | input | 1 | Slow shift clock, asynchronous to clk |
| strobe | input | 1 | Latch strobe: transparent while high, holds on its fall |
| out_en | input | 1 | Parallel output drive enable |
| par_q | output | 8 | Parallel outputs, `z` where not driven |
| par_data | output | 8 | Latch contents |
| par_drive | output | 8 | Per-bit drive enable for par_q |
| casc_rise | output | 1 | Cascade output, changes on the shift-clock rise |
| casc_fall | output | 1 | Cascade output, changes on the shift-clock fall |

## Verification
A wrong stage value shows on `casc_rise` only after it has walked up to stage 8, which can take up to eight shift periods. It shows on `par_data` one system cycle later if the strobe is open. A stale latch shows at once whenever `out_en` is high, while a wrongly held or wrongly shifted stage shows up as a byte that differs from the bits that were shifted in. A timing error between the two cascade outputs appears within half a shift period, when `casc_fall` fails to pick up the value `casc_rise` had before the falling edge.

// File: rtl/sr_pkg.sv
package sr_pkg;
    // bit positions inside the synchronised input vector
    localparam int unsigned SIG_SCLK = 0;
    localparam int unsigned SIG_STRB = 1;
    localparam int unsigned SIG_DATA = 2;
    localparam int unsigned SIG_N    = 3;
endpackage

// File: rtl/sr_edge_sync.sv
module sr_edge_sync #(
    parameter int unsigned N     = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    typedef struct packed {
        logic [DEPTH-1:0][N-1:0] chain;
        logic [N-1:0]            prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(DEPTH); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl_o  = st_q.chain[DEPTH-1];
    assign rise_o = st_q.chain[DEPTH-1] & ~st_q.prev;
    assign fall_o = ~st_q.chain[DEPTH-1] & st_q.prev;
endmodule

// File: rtl/sr_shift_core.sv
module sr_shift_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         fall_i,
    input  logic         din_i,
    output logic [W-1:0] stages_o,
    output logic         casc_rise_o,
    output logic         casc_fall_o
);
    localparam int unsigned TOP = W - 1;

    typedef struct packed {
        logic [W-1:0] stages;
        logic         cfall;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.stages = {st_q.stages[W-2:0], din_i};
        end
        if (fall_i) begin
            st_d.cfall = st_q.stages[TOP];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign stages_o    = st_q.stages;
    assign casc_rise_o = st_q.stages[TOP];
    assign casc_fall_o = st_q.cfall;
endmodule

// File: rtl/sr_hold_latch.sv
module sr_hold_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         open_i,
    input  logic         close_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] held;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // open: follow every cycle; close edge: one final capture
        if (open_i || close_i) begin
            st_d.held = d_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q_o = st_q.held;
endmodule

// File: rtl/sr_out_drive.sv
module sr_out_drive #(
    parameter int unsigned W = 8
) (
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] data_o,
    output logic [W-1:0] drive_o
);
    for (genvar b = 0; b < int'(W); b++) begin : g_bit
        assign data_o[b]  = d_i[b];
        assign drive_o[b] = en_i;
    end
endmodule

// File: rtl/shift_latch_top.sv
module shift_latch_top #(
    parameter int unsigned W          = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         shift_clk,
    input  logic         strobe,
    input  logic         out_en,
    output wire  [W-1:0] par_q,
    output logic [W-1:0] par_data,
    output logic [W-1:0] par_drive,
    output logic         casc_rise,
    output logic         casc_fall
);
    import sr_pkg::*;

    logic [SIG_N-1:0] in_raw, in_lvl, in_rise, in_fall;
    logic             sclk_rise, sclk_fall, strb_lvl, strb_fall, din_sync;
    logic [W-1:0]     stages, held;

    assign in_raw[SIG_SCLK] = shift_clk;
    assign in_raw[SIG_STRB] = strobe;
    assign in_raw[SIG_DATA] = ser_in;

    sr_edge_sync #(.N(SIG_N), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .async_i(in_raw),
        .lvl_o(in_lvl), .rise_o(in_rise), .fall_o(in_fall)
    );

    assign sclk_rise = in_rise[SIG_SCLK];
    assign sclk_fall = in_fall[SIG_SCLK];
    assign strb_lvl  = in_lvl[SIG_STRB];
    assign strb_fall = in_fall[SIG_STRB];
    assign din_sync  = in_lvl[SIG_DATA];

    sr_shift_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .step_i(sclk_rise), .fall_i(sclk_fall),
        .din_i(din_sync), .stages_o(stages),
        .casc_rise_o(casc_rise), .casc_fall_o(casc_fall)
    );

    sr_hold_latch #(.W(W)) u_latch (
        .clk(clk), .rst(rst), .open_i(strb_lvl), .close_i(strb_fall),
        .d_i(stages), .q_o(held)
    );

    sr_out_drive #(.W(W)) u_drv (
        .en_i(out_en), .d_i(held), .data_o(par_data), .drive_o(par_drive)
    );

    for (genvar b = 0; b < int'(W); b++) begin : g_tri
        assign par_q[b] = par_drive[b] ? par_data[b] : 1'bz;
    end
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         sclk_rise,
    input logic         sclk_fall,
    input logic         strb_lvl,
    input logic         strb_fall,
    input logic [W-1:0] stages,
    input logic [W-1:0] par_data,
    input logic         casc_rise,
    input logic         casc_fall
);
    // R2
    rise_cascade_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> casc_rise == $past(stages[W-2]));

    // R3
    fall_cascade_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_fall |=> casc_fall == $past(casc_rise));

    // R7
    no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_rise && !sclk_fall) |=> ($stable(stages) && $stable(casc_rise) && $stable(casc_fall)));

    // R4
    follow_open_chk: assert property (@(posedge clk) disable iff (rst)
        strb_lvl |=> par_data == $past(stages));

    // R5
    hold_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_lvl && !strb_fall) |=> $stable(par_data));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (stages == '0 && par_data == '0 && !casc_rise && !casc_fall));
endmodule

bind shift_latch_top sr_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .strb_lvl(strb_lvl), .strb_fall(strb_fall), .stages(stages),
    .par_data(par_data), .casc_rise(casc_rise), .casc_fall(casc_fall)
);

// File: tb/sim_shift_latch_top.sv
`timescale 1ns/1ps
module sim_shift_latch_top;
    logic       clk = 0;
    logic       rst = 1;
    logic       ser_in = 0, shift_clk = 0, strobe = 0, out_en = 0;
    wire  [7:0] par_q;
    logic [7:0] par_data, par_drive;
    logic       casc_rise, casc_fall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    shift_latch_top u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
        .strobe(strobe), .out_en(out_en), .par_q(par_q), .par_data(par_data),
        .par_drive(par_drive), .casc_rise(casc_rise), .casc_fall(casc_fall)
    );

    // behavioural reference: sampled histories and a bit queue (index 0 = stage 1)
    int m_clk[3], m_stb[3], m_dat[2];
    bit m_reg[$];
    bit m_latch[8];
    bit m_cfall;

    task automatic model_clear();
        m_reg.delete();
        for (int i = 0; i < 8; i++) begin m_reg.push_back(0); m_latch[i] = 0; end
        for (int i = 0; i < 3; i++) begin m_clk[i] = 0; m_stb[i] = 0; end
        m_dat[0] = 0; m_dat[1] = 0; m_cfall = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (rst) model_clear();
        else begin
            bit up, down, sfall;
            up    = (m_clk[1] == 1) && (m_clk[2] == 0);
            down  = (m_clk[1] == 0) && (m_clk[2] == 1);
            sfall = (m_stb[1] == 0) && (m_stb[2] == 1);
            if (m_stb[1] == 1 || sfall)
                for (int i = 0; i < 8; i++) m_latch[i] = m_reg[i];
            if (down) m_cfall = m_reg[7];
            if (up) begin
                m_reg.push_front(bit'(m_dat[1]));
                void'(m_reg.pop_back());
            end
            m_clk[2] = m_clk[1]; m_clk[1] = m_clk[0]; m_clk[0] = shift_clk;
            m_stb[2] = m_stb[1]; m_stb[1] = m_stb[0]; m_stb[0] = strobe;
            m_dat[1] = m_dat[0]; m_dat[0] = ser_in;
        end
    end

    function automatic logic [7:0] model_par();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[i] = m_latch[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(par_data == model_par(), "R4 par_data vs model", par_data, model_par());
            check(par_drive == {8{out_en}}, "R6 par_drive vs out_en", par_drive, {8{out_en}});
            check(casc_rise == m_reg[7], "R2 casc_rise vs model", {7'd0, casc_rise}, {7'd0, m_reg[7]});
            check(casc_fall == m_cfall, "R3 casc_fall vs model", {7'd0, casc_fall}, {7'd0, m_cfall});
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic shift_bit(input bit b);
        ser_in = b; shift_clk = 1; cyc(4);
        shift_clk = 0; cyc(4);
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic pulse_strobe();
        strobe = 1; cyc(4); strobe = 0; cyc(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 0; #1;
        // R8 reset state
        check(par_data == 8'h00 && !casc_rise && !casc_fall, "R8 reset state", par_data, 8'h00);
        out_en = 1;
        shift_byte(8'hA5);
        pulse_strobe();
        // R1 bit order and shifting
        check(par_q == 8'hA5, "R1 parallel after strobe", par_q, 8'hA5);
        check(casc_rise == 1'b1, "R2 cascade is stage 8", {7'd0, casc_rise}, 8'h01);
        // R5 hold while shifting with strobe low
        shift_byte(8'h3C);
        check(par_q == 8'hA5, "R5 held during shifting", par_q, 8'hA5);
        pulse_strobe();
        check(par_q == 8'h3C, "R4 new byte after strobe", par_q, 8'h3C);
        // R6 Hi-Z
        out_en = 0; #1;
        check(par_drive == 8'h00, "R6 drive off", par_drive, 8'h00);
        check(par_data == 8'h3C, "R6 latch kept while undriven", par_data, 8'h3C);
        out_en = 1; #1;
        check(par_drive == 8'hFF && par_q == 8'h3C, "R6 drive on", par_q, 8'h3C);
        // R7 strobe and out_en toggling do not touch cascades
        strobe = 1; out_en = 0; cyc(5); strobe = 0; out_en = 1; cyc(5);
        check(casc_rise == 1'b0 && casc_fall == 1'b0, "R7 cascades unchanged",
              {6'd0, casc_rise, casc_fall}, 8'h00);
        // stage 8 = 0 now; one shift keeps 0, the next brings 1 up from stage 7
        shift_bit(1'b0);
        ser_in = 1'b0; shift_clk = 1; cyc(2);
        // R9 not yet visible after two edges
        check(casc_rise == 1'b0, "R9 two-edge latency", {7'd0, casc_rise}, 8'h00);
        cyc(1);
        check(casc_rise == 1'b1, "R9 third edge update", {7'd0, casc_rise}, 8'h01);
        cyc(2);
        // R3 lag: fall output still old
        check(casc_fall == 1'b0, "R3 fall output lags", {7'd0, casc_fall}, 8'h00);
        shift_clk = 0; cyc(4);
        check(casc_fall == 1'b1, "R3 fall output after fall edge", {7'd0, casc_fall}, 8'h01);
        // R4 transparency: open strobe while shifting
        strobe = 1; cyc(4);
        shift_byte(8'h96);
        check(par_q == 8'h96, "R4 transparent follow", par_q, 8'h96);
        strobe = 0; cyc(4);
        shift_bit(1'b1);
        check(par_q == 8'h96, "R5 captured at strobe fall", par_q, 8'h96);
        // R8 reset mid-run
        rst = 1; cyc(2); rst = 0; #1;
        check(par_data == 8'h00 && !casc_rise && !casc_fall, "R8 reset clears", par_data, 8'h00);
        cyc(4);
        finish_run();
    end
endmodule